// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one SDRAM burst, one address per clock. A controller pulses `start` with the first column and a 4-bit burst configuration, which is the length code and the ordering bit of the mode-register value. From the next clock the block presents consecutive column addresses on `col_addr`, qualified by `col_valid`. On the final address of a fixed-length burst it also raises `col_last`.

For bursts of 2, 4 and 8, the addresses stay inside the aligned group of that many columns that holds the start column. They wrap inside that group in one of two orders. In linear order the low bits count upward. In interleaved order the low bits of the start column are XORed with the beat index. A full-page burst always counts linearly across the whole row and wraps from the top column back to zero. It runs until `stop` ends it. `stop` can also cut a fixed-length burst short.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it, `col_valid` and `col_last` are low.
- R2: A `start` sampled high with a supported length code sets `col_valid` high on the next clock, with `col_addr` equal to `start_col`. After that, one new address appears on every clock until the burst ends.
- R3: With `cfg[3]`=0 and a fixed length BL, beat i carries the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits are unchanged.
- R4: With `cfg[3]`=1 and a fixed length BL, beat i carries the start column with its low log2(BL) bits XORed with i.
- R5: `cfg[2:0]` codes 000, 001, 010 and 011 give bursts of exactly 1, 2, 4 and 8 beats. `col_valid` falls on the clock after the final beat.
- R6: `col_last` is high on the final beat of a fixed-length burst and low on every other beat.
- R7: Code 111 gives a full-page burst. It uses linear order whatever `cfg[3]` is, steps by one per clock, wraps from 511 to 0, never raises `col_last`, and continues until stopped.
- R8: A `stop` sampled high while `start` is low during a burst makes `col_valid` low from the next clock. The burst then has exactly the beats shown before that clock.
- R9: A `start` with a reserved length code (100, 101 or 110) is ignored, and no address is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a burst using `start_col` and `cfg` |
| start_col | input | 9 | First column of the burst |
| cfg | input | 4 | [2:0] length code, [3] interleaved ordering |
| stop | input | 1 | Ends the running burst |
| col_valid | output | 1 | `col_addr` holds a burst address this cycle |
| col_addr | output | 9 | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions assume that `start` and `stop` are never high on the same clock. They also assume that `cfg` matters only on the clock where `start` is sampled. In the full-page step property, the clock that follows a checked beat must not carry a new `start`. The bench keeps within these rules. It issues each start pulse only after the previous burst has drained, and it raises `stop` alone for a single clock. It also holds the configuration inputs steady for the whole pulse.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef struct packed {
    logic       ok;    // supported length code
    logic       full;  // full-page burst
    logic       ilv;   // interleaved ordering
    logic [1:0] lg;    // log2 of fixed burst length
  } bcg_mode_t;
endpackage

// File: rtl/bcg_mode_decode.sv
module bcg_mode_decode
  import bcg_pkg::*;
(
  input  logic [3:0] cfg,
  output bcg_mode_t  mode
);
  always_comb begin
    mode.full = (cfg[2:0] == 3'b111);
    mode.ok   = !cfg[2] || mode.full;
    mode.ilv  = cfg[3] && !mode.full;
    mode.lg   = mode.full ? 2'd0 : cfg[1:0];
  end
endmodule

// File: rtl/bcg_order.sv
module bcg_order
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  bcg_mode_t        mode,
  output logic [COL_W-1:0] addr
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] lin_sum;

  always_comb begin
    mask    = (ONE << mode.lg) - ONE;
    lin_sum = base + idx;
    if (mode.full)
      addr = lin_sum;
    else if (mode.ilv)
      addr = base ^ (idx & mask);
    else
      addr = (base & ~mask) | (lin_sum & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [3:0]       cfg,
  input  logic             stop,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last
);
  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  bcg_mode_t        dec_mode;
  bcg_mode_t        mode_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] beat_n;
  logic [COL_W-1:0] addr_n;
  logic [COL_W-1:0] len_m1_q;

  bcg_mode_decode u_dec (
    .cfg  (cfg),
    .mode (dec_mode)
  );

  assign beat_n   = beat_q + ONE;
  assign len_m1_q = (ONE << mode_q.lg) - ONE;

  bcg_order #(.COL_W(COL_W)) u_order (
    .base (base_q),
    .idx  (beat_n),
    .mode (mode_q),
    .addr (addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
      col_addr  <= '0;
      base_q    <= '0;
      beat_q    <= '0;
      mode_q    <= '0;
    end else if (start && dec_mode.ok) begin
      base_q    <= start_col;
      mode_q    <= dec_mode;
      beat_q    <= '0;
      col_addr  <= start_col;
      col_valid <= 1'b1;
      col_last  <= !dec_mode.full && (dec_mode.lg == 2'd0);
    end else if (col_valid && (stop || col_last)) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (col_valid) begin
      beat_q    <= beat_n;
      col_addr  <= addr_n;
      col_last  <= !mode_q.full && (beat_n == len_m1_q);
    end
  end

  // R6: the last flag only ever marks a live beat
  a_r6_last_is_valid: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R7: full-page bursts never flag a last beat
  a_r7_full_no_last: assert property (@(posedge clk) disable iff (rst)
    (col_valid && mode_q.full) |-> !col_last);

  // R7: full-page bursts advance by one column per clock
  a_r7_full_step: assert property (@(posedge clk) disable iff (rst)
    (col_valid && mode_q.full && !start && !stop) |=>
      (col_valid && col_addr == COL_W'($past(col_addr) + ONE)));

  // R3: fixed bursts stay inside the aligned group of the start column
  a_r3_group_fixed: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !mode_q.full) |-> (((col_addr ^ base_q) & ~len_m1_q) == '0));

  // R5: the burst ends the clock after its final beat
  a_r5_end_after_last: assert property (@(posedge clk) disable iff (rst)
    (col_last && !start) |=> !col_valid);

  // R8: stop ends the burst on the next clock
  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (col_valid && stop && !start) |=> !col_valid);
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic [3:0] cfg = '0;
  logic       stop = 1'b0;
  logic       col_valid;
  logic [8:0] col_addr;
  logic       col_last;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  int    q_addr[$];
  bit    q_last[$];
  string q_tag[$];

  always #5 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col), .cfg(cfg),
    .stop(stop), .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && col_valid && !finished) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R9/R5/R8 unexpected beat", col_addr, -1);
      end else begin
        int    ea;
        bit    el;
        string t;
        ea = q_addr.pop_front();
        el = q_last.pop_front();
        t  = q_tag.pop_front();
        check(col_addr == ea[8:0], {t, " addr"}, col_addr, ea);
        check(col_last == el, {t, " last R6"}, col_last, el);
      end
    end
  end

  function automatic int exp_addr(input int base, input int code, input bit ilv, input int i);
    int bl, blk, lo;
    if (code == 7) return (base + i) % 512;
    bl  = 1 << code;
    blk = base - (base % bl);
    lo  = base % bl;
    if (ilv) return blk + (lo ^ i);
    return blk + ((lo + i) % bl);
  endfunction

  // stop_after = 0 means run the full fixed length
  task automatic burst(input int base, input bit ilv, input int code,
                       input int stop_after, input string tag);
    int n, bl;
    bl = (code == 7) ? 0 : (1 << code);
    n  = (stop_after > 0) ? stop_after : bl;
    for (int i = 0; i < n; i++) begin
      q_addr.push_back(exp_addr(base, code, ilv, i));
      q_last.push_back(code != 7 && i == bl - 1);
      q_tag.push_back(tag);
    end
    @(posedge clk); #1;
    start = 1'b1; start_col = base[8:0]; cfg = {ilv, code[2:0]};
    @(posedge clk); #1;
    start = 1'b0;
    if (stop_after > 0) begin
      repeat (stop_after - 1) @(posedge clk);
      #1 stop = 1'b1;
      @(posedge clk); #1;
      stop = 1'b0;
      repeat (3) @(posedge clk);
    end else begin
      repeat (n + 2) @(posedge clk);
    end
    #1;
    check(q_addr.size() == 0, {tag, " all beats seen R2"}, q_addr.size(), 0);
    check(col_valid == 1'b0, {tag, " burst ended R5/R8"}, col_valid, 0);
  endtask

  task automatic reserved(input logic [3:0] c, input string tag);
    @(posedge clk); #1;
    start = 1'b1; start_col = 9'd40; cfg = c;
    @(posedge clk); #1;
    start = 1'b0;
    check(col_valid == 1'b0, tag, col_valid, 0);
    repeat (3) @(posedge clk); #1;
    check(col_valid == 1'b0, tag, col_valid, 0);
  endtask

  initial begin
    #1;
    check(col_valid == 1'b0 && col_last == 1'b0, "R1 in reset", col_valid, 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    check(col_valid == 1'b0 && col_last == 1'b0, "R1 after reset", col_valid, 0);

    burst(13,  1'b0, 3, 0, "R3 seq BL8");
    burst(13,  1'b1, 3, 0, "R4 ilv BL8");
    burst(510, 1'b0, 2, 0, "R3 seq BL4");
    burst(6,   1'b1, 2, 0, "R4 ilv BL4");
    burst(3,   1'b0, 1, 0, "R5 seq BL2");
    burst(3,   1'b1, 1, 0, "R4 ilv BL2");
    burst(77,  1'b0, 0, 0, "R5 BL1");
    burst(77,  1'b1, 0, 0, "R5 BL1 ilv");
    burst(508, 1'b0, 7, 8, "R7 full wrap");
    burst(100, 1'b1, 7, 3, "R7 full ilv bit");
    burst(2,   1'b0, 3, 3, "R8 stop BL8");
    burst(300, 1'b0, 7, 1, "R8 stop full");
    burst(255, 1'b1, 3, 5, "R8 stop ilv");
    reserved(4'b0100, "R9 code 100");
    reserved(4'b1101, "R9 code 101");
    reserved(4'b0110, "R9 code 110");
    burst(0,   1'b0, 2, 0, "R2 after reserved");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule